// File: doc/BRIEF.md
# Standard-Identifier Acceptance Filter with Shared Mask

This block decides which of fourteen receive slots, here called centers, accept an incoming 11-bit standard identifier. Each center has its own enable bit and an 11-bit compare value. All centers share one global mask. A mask bit set to 1 makes that identifier bit significant. A mask bit set to 0 makes it a don't-care. The mask is held in two byte-wide registers. Software can rewrite them only while the controller's initialization flag is raised.

For each received identifier, the frame receiver pulses a valid strobe together with the identifier and its format flag. The block captures these and compares them against every center. It then returns a per-center hit vector, the number of the lowest center that hit and a summary hit flag. A mask-enable input turns the mask off, so that every bit must match exactly. Frames flagged as extended still produce a result, but that result never reports a hit from this standard-ID filter.

Top module: `stdid_mask_filter`

## Requirements
- R1: After reset, both mask registers read 00h and `res_valid`, `res_vec`, `res_idx` and `res_hit` are 0.
- R2: The byte at offset 06h holds identifier mask bits 10..3 in data bits 7..0. The byte at offset 07h holds mask bits 2..0 in data bits 7..5. Every other offset reads 00h.
- R3: With `mask_on`=1, a center whose mask bits are 1 hits only if the identifier equals its compare value in those bit positions. Identifier bits whose mask bit is 0 do not affect the result.
- R4: With `mask_on`=0, the stored mask has no effect, and a center hits only when all 11 identifier bits equal its compare value.
- R5: A frame with `frm_ext`=1 produces a result with `res_vec`=0 and `res_hit`=0, whatever the mask and compare values are.
- R6: A register write with `cfg_init`=0 is dropped, and the mask keeps its previous value.
- R7: Data bits 4..0 at offset 07h always read 0. Writes to them have no effect, and they take part in no comparison.
- R8: A center whose `ctr_en` bit is 0 never sets its bit in `res_vec`.
- R9: A strobe sampled on a rising edge yields `res_valid`=1 for exactly one cycle after the second rising edge that follows. In all other cycles `res_valid`, `res_vec`, `res_idx` and `res_hit` are 0. Strobes may arrive back to back.
- R10: `res_vec` bit k-1 stands for center k, for k from 1 to 14. `res_idx` gives the lowest center number with its bit set, or 0 when none is set. `res_hit` is 1 exactly when `res_vec` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_init | input | 1 | Initialization flag; mask writes take effect only while it is 1 |
| mask_on | input | 1 | 1 applies the mask, 0 forces exact matching |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| ctr_en | input | 14 | Per-center enable; bit k-1 is center k |
| ctr_arb | input | 154 | Compare values; center k uses bits 11k-1 down to 11(k-1) |
| frm_valid | input | 1 | Identifier strobe |
| frm_id | input | 11 | Received standard identifier |
| frm_ext | input | 1 | 1 marks an extended-format frame |
| res_valid | output | 1 | Result strobe |
| res_vec | output | 14 | Per-center hit vector |
| res_idx | output | 4 | Lowest hitting center number, 0 if none |
| res_hit | output | 1 | Any center hit |

## Verification
If the stored mask is corrupted, every hit vector produced afterwards is wrong, two cycles after each strobe. Register reads show the corruption in the same cycle the offset is presented. A write that slips past the initialization lock is visible on the next read-back. It also shows in the acceptance pattern of the next frame, because tests that should be exact begin to accept neighbouring identifiers. A fault in the priority encoder or the format gating shows up only when several centers hit at once or when an extended frame arrives, so the stimulus deliberately sets up duplicate compare values and extended frames.

// File: rtl/stdid_filt_pkg.sv
package stdid_filt_pkg;

  localparam int STD_ID_W = 11;
  localparam int BYTE_W   = 8;

  // Masked equality: every bit selected by mask must agree.
  function automatic logic masked_eq(input logic [STD_ID_W-1:0] id,
                                     input logic [STD_ID_W-1:0] ref_val,
                                     input logic [STD_ID_W-1:0] mask);
    return ((id ^ ref_val) & mask) == '0;
  endfunction

  // Captured frame in the compare stage.
  typedef struct packed {
    logic                valid;
    logic                ext;
    logic [STD_ID_W-1:0] id;
  } stg_frame_t;

endpackage

// File: rtl/stdid_mask_regs.sv
module stdid_mask_regs
  import stdid_filt_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] OFS_HI  = 8'h06,
  parameter logic [ADDR_W-1:0] OFS_LO  = 8'h07
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                unlock,
  output logic [STD_ID_W-1:0] mask_q,
  output logic [BYTE_W-1:0]   rdata,
  output logic                wr_taken,
  output logic                wr_dropped
);

  localparam int LO_BITS = STD_ID_W - BYTE_W;
  localparam int PAD_W   = BYTE_W - LO_BITS;

  logic hit_hi, hit_lo;

  assign hit_hi     = (addr == OFS_HI);
  assign hit_lo     = (addr == OFS_LO);
  assign wr_taken   = wr && unlock && (hit_hi || hit_lo);
  assign wr_dropped = wr && !unlock && (hit_hi || hit_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_taken) begin
      if (hit_hi) mask_q[STD_ID_W-1:LO_BITS] <= wdata;
      if (hit_lo) mask_q[LO_BITS-1:0]        <= wdata[BYTE_W-1:PAD_W];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_hi) rdata = mask_q[STD_ID_W-1:LO_BITS];
    else if (hit_lo) rdata = {mask_q[LO_BITS-1:0], {PAD_W{1'b0}}};
  end

endmodule

// File: rtl/stdid_center_cmp.sv
module stdid_center_cmp
  import stdid_filt_pkg::*;
#(
  parameter int NUM_CTR = 14
) (
  input  logic [STD_ID_W-1:0]         id,
  input  logic                        ext,
  input  logic                        active,
  input  logic [STD_ID_W-1:0]         eff_mask,
  input  logic [NUM_CTR-1:0]          ctr_en,
  input  logic [NUM_CTR*STD_ID_W-1:0] ctr_arb,
  output logic [NUM_CTR-1:0]          hit_vec
);

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    logic [STD_ID_W-1:0] arb_k;
    assign arb_k      = ctr_arb[k*STD_ID_W +: STD_ID_W];
    assign hit_vec[k] = active && !ext && ctr_en[k] &&
                        masked_eq(id, arb_k, eff_mask);
  end

endmodule

// File: rtl/stdid_first_hit.sv
module stdid_first_hit #(
  parameter int NUM_CTR = 14,
  parameter int IDX_W   = $clog2(NUM_CTR + 1)
) (
  input  logic [NUM_CTR-1:0] vec,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);

  // Scan from the top so the lowest set bit is the last writer.
  function automatic logic [IDX_W-1:0] lowest_num(input logic [NUM_CTR-1:0] v);
    logic [IDX_W-1:0] n;
    n = '0;
    for (int k = NUM_CTR - 1; k >= 0; k--) begin
      if (v[k]) n = IDX_W'(k + 1);
    end
    return n;
  endfunction

  assign idx = lowest_num(vec);
  assign any = |vec;

endmodule

// File: rtl/stdid_mask_filter.sv
module stdid_mask_filter
  import stdid_filt_pkg::*;
#(
  parameter int NUM_CTR = 14,
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = $clog2(NUM_CTR + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_init,
  input  logic                        mask_on,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [7:0]                  reg_wdata,
  output logic [7:0]                  reg_rdata,
  input  logic [NUM_CTR-1:0]          ctr_en,
  input  logic [NUM_CTR*11-1:0]       ctr_arb,
  input  logic                        frm_valid,
  input  logic [10:0]                 frm_id,
  input  logic                        frm_ext,
  output logic                        res_valid,
  output logic [NUM_CTR-1:0]          res_vec,
  output logic [IDX_W-1:0]            res_idx,
  output logic                        res_hit
);

  localparam logic [ADDR_W-1:0] OFS_HI = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFS_LO = ADDR_W'(7);

  logic [STD_ID_W-1:0] mask_q;
  logic [STD_ID_W-1:0] eff_mask;
  logic                wr_taken, wr_dropped;
  stg_frame_t          stg_q;
  logic [NUM_CTR-1:0]  cmp_vec;
  logic [IDX_W-1:0]    cmp_idx;
  logic                cmp_any;

  stdid_mask_regs #(
    .ADDR_W (ADDR_W),
    .OFS_HI (OFS_HI),
    .OFS_LO (OFS_LO)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .unlock     (cfg_init),
    .mask_q     (mask_q),
    .rdata      (reg_rdata),
    .wr_taken   (wr_taken),
    .wr_dropped (wr_dropped)
  );

  // Stage 1: capture the strobe and identifier.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= '{valid: frm_valid, ext: frm_ext, id: frm_id};
  end

  assign eff_mask = mask_on ? mask_q : '1;

  stdid_center_cmp #(.NUM_CTR(NUM_CTR)) u_cmp (
    .id       (stg_q.id),
    .ext      (stg_q.ext),
    .active   (stg_q.valid),
    .eff_mask (eff_mask),
    .ctr_en   (ctr_en),
    .ctr_arb  (ctr_arb),
    .hit_vec  (cmp_vec)
  );

  stdid_first_hit #(.NUM_CTR(NUM_CTR), .IDX_W(IDX_W)) u_pri (
    .vec (cmp_vec),
    .idx (cmp_idx),
    .any (cmp_any)
  );

  // Stage 2: register the result.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_vec   <= '0;
      res_idx   <= '0;
      res_hit   <= 1'b0;
    end else begin
      res_valid <= stg_q.valid;
      res_vec   <= cmp_vec;
      res_idx   <= cmp_idx;
      res_hit   <= cmp_any;
    end
  end

endmodule

// File: rtl/stdid_mask_filter_chk.sv
module stdid_mask_filter_chk #(
  parameter int NUM_CTR = 14,
  parameter int IDX_W   = 4,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_init,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [7:0]         reg_rdata,
  input logic [10:0]        mask_q,
  input logic               wr_dropped,
  input logic               stg_valid,
  input logic               stg_ext,
  input logic [NUM_CTR-1:0] ctr_en,
  input logic               res_valid,
  input logic [NUM_CTR-1:0] res_vec,
  input logic [IDX_W-1:0]   res_idx,
  input logic               res_hit
);

  logic [NUM_CTR-1:0] below_idx;
  assign below_idx = (res_idx == '0) ? '0 :
                     ((NUM_CTR'(1) << (res_idx - IDX_W'(1))) - NUM_CTR'(1));

  AST_LOCKED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_init |=> $stable(mask_q)); // R6

  AST_DROPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dropped |=> $stable(mask_q)); // R6

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(7)) |-> (reg_rdata[4:0] == 5'd0)); // R7

  AST_EXT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_valid && stg_ext) |=> (res_valid && res_vec == '0 && !res_hit)); // R5

  AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    stg_valid |=> res_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_vec == '0 && res_idx == '0 && !res_hit)); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_vec & ~$past(ctr_en)) == '0)); // R8

  AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit == (res_vec != '0)); // R10

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_vec[res_idx - IDX_W'(1)] && (res_vec & below_idx) == '0)); // R10

endmodule

bind stdid_mask_filter stdid_mask_filter_chk #(
  .NUM_CTR (NUM_CTR),
  .IDX_W   (IDX_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_init   (cfg_init),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .mask_q     (mask_q),
  .wr_dropped (wr_dropped),
  .stg_valid  (stg_q.valid),
  .stg_ext    (stg_q.ext),
  .ctr_en     (ctr_en),
  .res_valid  (res_valid),
  .res_vec    (res_vec),
  .res_idx    (res_idx),
  .res_hit    (res_hit)
);

// File: tb/tb_stdid_mask_filter.sv
module tb_stdid_mask_filter;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_init = 1'b0;
  logic          mask_on = 1'b1;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [NC-1:0] ctr_en = '1;
  logic [NC*11-1:0] ctr_arb;
  logic          frm_valid = 1'b0;
  logic [10:0]   frm_id = '0;
  logic          frm_ext = 1'b0;
  logic          res_valid;
  logic [NC-1:0] res_vec;
  logic [3:0]    res_idx;
  logic          res_hit;

  logic [10:0] arb [NC];
  logic [10:0] mdl_mask = '0;   // bench's own view of the mask

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NC-1:0] vec;
    logic [3:0]    idx;
    logic          hit;
    string         tag;
  } exp_t;
  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < NC; k++) ctr_arb[k*11 +: 11] = arb[k];
  end

  stdid_mask_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .mask_on(mask_on),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctr_en(ctr_en), .ctr_arb(ctr_arb),
    .frm_valid(frm_valid), .frm_id(frm_id), .frm_ext(frm_ext),
    .res_valid(res_valid), .res_vec(res_vec), .res_idx(res_idx),
    .res_hit(res_hit)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    // Bench model of the write rule (R6, R7).
    if (cfg_init) begin
      if (a == 8'h06) mdl_mask[10:3] = d;
      if (a == 8'h07) mdl_mask[2:0]  = d[7:5];
    end
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, tag, 32'(reg_rdata), 32'(exp));
  endtask

  // Driver: computes the expected result and sends one strobe.
  task automatic send(input logic [10:0] id, input logic ext, input string tag);
    exp_t e;
    logic [10:0] m;
    m = mask_on ? mdl_mask : 11'h7FF;
    e.vec = '0; e.idx = '0; e.tag = tag;
    for (int k = 0; k < NC; k++) begin
      if (ctr_en[k] && !ext && (((id ^ arb[k]) & m) == 11'h000)) e.vec[k] = 1'b1;
    end
    for (int k = NC - 1; k >= 0; k--) if (e.vec[k]) e.idx = 4'(k + 1);
    e.hit = (e.vec != '0);
    sbq.push_back(e);
    frm_id = id; frm_ext = ext; frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R9 unexpected result", 32'(res_vec), 32'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(res_vec == e.vec, {e.tag, " vec (R10)"}, 32'(res_vec), 32'(e.vec));
        check(res_idx == e.idx && res_hit == e.hit, {e.tag, " idx/hit (R10)"},
              {27'd0, res_hit, res_idx}, {27'd0, e.hit, e.idx});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NC; k++) arb[k] = 11'(k * 93 + 17);
    arb[0] = 11'h123; arb[1] = 11'h456; arb[2] = 11'h123;
    arb[3] = 11'h7FF; arb[4] = 11'h055;
    ctr_en = '1;
    ctr_en[4] = 1'b0;

    repeat (3) @(negedge clk);
    // R1: reset state
    rd_reg(8'h06, 8'h00, "R1 mask hi after reset");
    rd_reg(8'h07, 8'h00, "R1 mask lo after reset");
    check(res_valid == 1'b0 && res_vec == '0, "R1 outputs in reset",
          32'(res_vec), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R7: register map and padding bits
    cfg_init = 1'b1;
    wr_reg(8'h06, 8'hFF);
    wr_reg(8'h07, 8'hFF);
    rd_reg(8'h06, 8'hFF, "R2 hi byte");
    rd_reg(8'h07, 8'hE0, "R7 padding reads zero");
    rd_reg(8'h05, 8'h00, "R2 unmapped offset");
    wr_reg(8'h07, 8'h1F);
    rd_reg(8'h07, 8'h00, "R7 padding write ignored");
    wr_reg(8'h07, 8'hE0);

    // R6: lock
    cfg_init = 1'b0;
    wr_reg(8'h06, 8'h00);
    wr_reg(8'h07, 8'h00);
    rd_reg(8'h06, 8'hFF, "R6 locked hi");
    rd_reg(8'h07, 8'hE0, "R6 locked lo");

    // R9: latency, sampled between edges
    frm_id = 11'h456; frm_ext = 1'b0; frm_valid = 1'b1;
    sbq.push_back('{vec: 14'h0002, idx: 4'd2, hit: 1'b1, tag: "R9 latency"});
    @(negedge clk); frm_valid = 1'b0;
    check(res_valid == 1'b0, "R9 not yet valid", 32'(res_valid), 32'd0);
    @(negedge clk);
    check(res_valid == 1'b1, "R9 valid after second edge", 32'(res_valid), 32'd1);
    @(negedge clk);
    check(res_valid == 1'b0, "R9 single cycle", 32'(res_valid), 32'd0);
    drain();

    // R3 full mask, R8 disabled center, R10 duplicate priority, back to back
    send(11'h123, 1'b0, "R10 dup centers");
    send(11'h456, 1'b0, "R3 full mask");
    send(11'h055, 1'b0, "R8 disabled center");
    send(11'h7FF, 1'b0, "R3 top value");
    send(11'h124, 1'b0, "R3 one bit off");
    // R5 extended frames
    send(11'h123, 1'b1, "R5 extended");
    send(11'h7FF, 1'b1, "R5 extended top");
    drain();

    // R3 mask of zero: every enabled center hits
    cfg_init = 1'b1;
    wr_reg(8'h06, 8'h00);
    wr_reg(8'h07, 8'h00);
    cfg_init = 1'b0;
    send(11'h3A5, 1'b0, "R3 all dont-care");
    send(11'h3A5, 1'b1, "R5 extended all dont-care");
    // R4 mask off forces exact matching
    mask_on = 1'b0;
    send(11'h3A5, 1'b0, "R4 exact no hit");
    send(11'h123, 1'b0, "R4 exact hit");
    drain();
    mask_on = 1'b1;

    // R3 only upper three bits significant
    cfg_init = 1'b1;
    wr_reg(8'h06, 8'hE0);
    cfg_init = 1'b0;
    send(11'h100, 1'b0, "R3 top three bits");
    send(11'h7A0, 1'b0, "R3 top three ones");
    drain();

    // R3 / R7 only lowest three bits significant
    cfg_init = 1'b1;
    wr_reg(8'h06, 8'h00);
    wr_reg(8'h07, 8'hFF);
    cfg_init = 1'b0;
    send(11'h003, 1'b0, "R3 low three bits");
    send(11'h557, 1'b0, "R3 low bits seven");
    drain();

    // R8 / R10 priority moves when center 1 is disabled
    ctr_en[0] = 1'b0;
    @(negedge clk);
    send(11'h7F3, 1'b0, "R8 center1 off");
    drain();
    ctr_en[0] = 1'b1;
    @(negedge clk);
    send(11'h7F3, 1'b0, "R10 center1 back");
    drain();

    check(sbq.size() == 0, "R9 all results delivered", 32'(sbq.size()), 32'd0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule